// File: doc/BRIEF.md
# Real-Time Clock Timebase, Alarm and Interrupt Core

This block is the timekeeping heart of a real-time clock. A slow base enable, nominally at 32.768 kHz, drives a prescaler that can be started, frozen or held cleared by a divider-select field. Each time the prescaler wraps, the core advances a 24-hour time of day held as seconds, minutes and hours. The fields count in packed BCD or in plain binary. After each advance it compares the new time against three alarm bytes. The same prescaler also produces a programmable periodic event whose rate is a power of two of the base.

Software reaches the core through an index/data register pair. A write with the select pin low loads the index. Writes and reads with the select pin high go to the register that the index names. The read data is combinational from the current index. Three event flags (periodic, alarm, update-ended) latch until the flag register is read. Any flag whose enable is set drives a combined request bit and the `irq` pin. A status bit warns software that a time advance is about to happen, so it does not read the time fields in the middle of one.

Top module: `rtc_core`

## Requirements
- R1: After reset, control register A (index 0Ah) reads 20h, control register B (0Bh) reads 00h, the flag register (0Ch) reads 00h, all time and alarm bytes read 00h and `irq` is low.
- R2: The prescaler advances once per `tick_base` only while A bits 6:4 equal 010. Codes 110 and 111 clear it and hold it at zero. Every other code freezes it, so neither a periodic nor an update event can occur.
- R3: When A bits 3:0 (rate) are nonzero, a periodic event occurs every 2^(rate-1) prescaler steps for rates 3 to 15. Rates 1 and 2 give 128 and 256 steps. Each event sets the flag-register bit 6. Rate 0 produces no events.
- R4: A bit 7 is read-only. While the prescaler runs and updates are not halted, it reads 1 for the 8 prescaler steps before each time advance, and it reads 0 from the cycle in which the update-ended flag sets.
- R5: Every 2^SEC_LOG2 prescaler steps (32768 by default), seconds (index 00h) advance. Minutes (02h) carry at 59 and hours (04h) carry at 59 minutes. Hours wrap from 23 to 00.
- R6: B bit 2 = 0 selects packed BCD for the time fields (59 is 59h), and 1 selects binary (59 is 3Bh). A software write to a time field takes priority over an advance in the same cycle.
- R7: B bit 7 = 1 halts time advances. While halted, the time fields do not change, the update-ended flag does not set and A bit 7 stays 0.
- R8: Each time advance sets the flag-register bit 4 (update ended).
- R9: On a time advance, the alarm flag (flag-register bit 5) sets when each new time field equals its alarm byte (01h, 03h, 05h). An alarm byte with bits 7:6 both 1 matches any value.
- R10: Flag-register bit 7 and `irq` are 1 exactly when some flag is set together with its enable: periodic with B bit 6, alarm with B bit 5, update-ended with B bit 4. The flag-register bits 3:0 read 0.
- R11: A data read (`bus_rd` with `bus_sel` high) while the index is 0Ch clears all flags at that edge. A flag event in the same cycle still sets its flag.
- R12: Index 0Dh reads 80h. Writes to 0Ch and 0Dh are ignored. Indices with no register read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_base | input | 1 | One-cycle enable per base-oscillator period |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only side effect: clearing flags at index 0Ch) |
| bus_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Contents of the register named by the index |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The hardest states to reach are the ones tied to the once-per-second advance. These are the short status window, the alarm match on a carry through every field, and the hour wrap. By default each of them is 32768 base steps away. The stimulus holds the prescaler in reset, loads 23:59:58 and alarm bytes that need a full wrap to match, then releases the prescaler and polls the status bit so the checks land on the exact cycles around each advance. The same approach runs again in binary mode and with updates halted. A behavioural model in the bench tracks every register and compares the read port and `irq` on every cycle.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  localparam int NFIELD = 3;

  localparam logic [2:0] DV_RUN = 3'b010;

  localparam logic [7:0] REG_A_RST = 8'h20;

  localparam int IX_CTLA = 8'h0A;
  localparam int IX_CTLB = 8'h0B;
  localparam int IX_FLAG = 8'h0C;
  localparam int IX_PWR  = 8'h0D;

  typedef struct packed {
    logic halt;
    logic per_en;
    logic alm_en;
    logic upd_en;
    logic spare3;
    logic bin;
    logic spare1;
    logic spare0;
  } ctl_b_t;

  function automatic logic [7:0] field_top_bin(int i);
    return (i == NFIELD - 1) ? 8'd23 : 8'd59;
  endfunction

  function automatic logic [7:0] to_bcd(logic [7:0] b);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = b / 8'd10;
    ones = b % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] step_val(logic [7:0] v, logic bin);
    if (bin) return v + 8'd1;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [3:0] per_shift(logic [3:0] rate);
    case (rate)
      4'd1:    return 4'd7;
      4'd2:    return 4'd8;
      default: return rate - 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
`timescale 1ns/1ps
module rtc_prescale
  import rtc_pkg::*;
#(
  parameter int SEC_LOG2 = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [2:0]          dv,
  input  logic [3:0]          rate,
  input  logic                halt,
  output logic [SEC_LOG2-1:0] cnt_q,
  output logic                run,
  output logic                hold,
  output logic                per_ev,
  output logic                sec_ev,
  output logic                uip
);

  localparam int CW = SEC_LOG2;
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic          step_en;
  logic [CW-1:0] per_mask;

  assign run     = (dv == DV_RUN);
  assign hold    = (dv[2:1] == 2'b11);
  assign step_en = tick & run;

  always_comb begin
    per_mask = (CW'(1) << per_shift(rate)) - CW'(1);
  end

  assign per_ev = step_en & (rate != 4'd0) & ((cnt_q | ~per_mask) == CNT_TOP);
  assign sec_ev = step_en & ~halt & (cnt_q == CNT_TOP);

  generate
    if (UIP_LEAD > 0) begin : g_uip
      localparam logic [CW-1:0] UIP_START = CW'((1 << CW) - UIP_LEAD);
      assign uip = run & ~halt & (cnt_q >= UIP_START);
    end else begin : g_no_uip
      assign uip = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (hold)    cnt_q <= '0;
    else if (step_en) cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/rtc_field.sv
`timescale 1ns/1ps
module rtc_field
  import rtc_pkg::*;
#(
  parameter logic [7:0] TOP_BIN = 8'd59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       bin,
  input  logic       wr_val,
  input  logic       wr_alm,
  input  logic [7:0] wdata,
  output logic [7:0] val,
  output logic [7:0] alm,
  output logic       carry,
  output logic       match
);

  localparam logic [7:0] TOP_BCD = to_bcd(TOP_BIN);

  logic [7:0] top;
  logic [7:0] nxt;
  logic       at_top;

  assign top    = bin ? TOP_BIN : TOP_BCD;
  assign at_top = (val == top);
  assign carry  = inc & at_top;

  always_comb begin
    if (!inc)        nxt = val;
    else if (at_top) nxt = 8'h00;
    else             nxt = step_val(val, bin);
  end

  assign match = (alm[7:6] == 2'b11) | (alm == nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= 8'h00;
      alm <= 8'h00;
    end else begin
      if (wr_val)   val <= wdata;
      else if (inc) val <= nxt;
      if (wr_alm)   alm <= wdata;
    end
  end

endmodule

// File: rtl/rtc_timekeep.sv
`timescale 1ns/1ps
module rtc_timekeep
  import rtc_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sec_ev,
  input  logic                        bin,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [7:0]                  wdata,
  output logic [NFIELD-1:0][7:0]      val,
  output logic [NFIELD-1:0][7:0]      alm,
  output logic                        alarm_hit
);

  logic [NFIELD:0]   inc_chain;
  logic [NFIELD-1:0] hit;

  assign inc_chain[0] = sec_ev;

  generate
    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
      logic wr_v;
      logic wr_a;
      assign wr_v = wr_en & (wr_idx == IDX_W'(2 * i));
      assign wr_a = wr_en & (wr_idx == IDX_W'(2 * i + 1));

      rtc_field #(.TOP_BIN(field_top_bin(i))) u_fld (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (inc_chain[i]),
        .bin    (bin),
        .wr_val (wr_v),
        .wr_alm (wr_a),
        .wdata  (wdata),
        .val    (val[i]),
        .alm    (alm[i]),
        .carry  (inc_chain[i+1]),
        .match  (hit[i])
      );
    end
  endgenerate

  assign alarm_hit = sec_ev & (&hit);

endmodule

// File: rtl/rtc_flags.sv
`timescale 1ns/1ps
module rtc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic per_ev,
  input  logic upd_ev,
  input  logic alm_ev,
  input  logic clr,
  input  logic en_per,
  input  logic en_alm,
  input  logic en_upd,
  output logic pf,
  output logic af,
  output logic uf,
  output logic irqf
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf <= 1'b0;
      af <= 1'b0;
      uf <= 1'b0;
    end else begin
      pf <= (pf & ~clr) | per_ev;
      af <= (af & ~clr) | alm_ev;
      uf <= (uf & ~clr) | upd_ev;
    end
  end

  assign irqf = (pf & en_per) | (af & en_alm) | (uf & en_upd);

endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
  import rtc_pkg::*;
#(
  parameter int SEC_LOG2 = 15,
  parameter int UIP_LEAD = 8,
  parameter int IDX_W    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_base,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);

  logic [IDX_W-1:0]         idx_q;
  logic [6:0]               ctl_a;
  ctl_b_t                   ctl_b;
  logic [SEC_LOG2-1:0]      div_cnt;
  logic                     div_run;
  logic                     div_hold;
  logic                     per_ev;
  logic                     sec_ev;
  logic                     uip;
  logic [NFIELD-1:0][7:0]   tm_val;
  logic [NFIELD-1:0][7:0]   tm_alm;
  logic                     alarm_hit;
  logic                     pf, af, uf, irqf;
  logic                     data_wr;
  logic                     clr_flags;

  assign data_wr   = bus_wr & bus_sel;
  assign clr_flags = bus_rd & bus_sel & (idx_q == IDX_W'(IX_FLAG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ctl_a <= REG_A_RST[6:0];
      ctl_b <= '0;
    end else begin
      if (bus_wr & ~bus_sel) idx_q <= bus_wdata[IDX_W-1:0];
      if (data_wr & (idx_q == IDX_W'(IX_CTLA))) ctl_a <= bus_wdata[6:0];
      if (data_wr & (idx_q == IDX_W'(IX_CTLB))) ctl_b <= ctl_b_t'(bus_wdata);
    end
  end

  rtc_prescale #(.SEC_LOG2(SEC_LOG2), .UIP_LEAD(UIP_LEAD)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_base),
    .dv     (ctl_a[6:4]),
    .rate   (ctl_a[3:0]),
    .halt   (ctl_b.halt),
    .cnt_q  (div_cnt),
    .run    (div_run),
    .hold   (div_hold),
    .per_ev (per_ev),
    .sec_ev (sec_ev),
    .uip    (uip)
  );

  rtc_timekeep #(.IDX_W(IDX_W)) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_ev    (sec_ev),
    .bin       (ctl_b.bin),
    .wr_en     (data_wr),
    .wr_idx    (idx_q),
    .wdata     (bus_wdata),
    .val       (tm_val),
    .alm       (tm_alm),
    .alarm_hit (alarm_hit)
  );

  rtc_flags u_flg (
    .clk    (clk),
    .rst_n  (rst_n),
    .per_ev (per_ev),
    .upd_ev (sec_ev),
    .alm_ev (alarm_hit),
    .clr    (clr_flags),
    .en_per (ctl_b.per_en),
    .en_alm (ctl_b.alm_en),
    .en_upd (ctl_b.upd_en),
    .pf     (pf),
    .af     (af),
    .uf     (uf),
    .irqf   (irqf)
  );

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NFIELD; i++) begin
      if (idx_q == IDX_W'(2 * i))     bus_rdata = tm_val[i];
      if (idx_q == IDX_W'(2 * i + 1)) bus_rdata = tm_alm[i];
    end
    if (idx_q == IDX_W'(IX_CTLA)) bus_rdata = {uip, ctl_a};
    if (idx_q == IDX_W'(IX_CTLB)) bus_rdata = ctl_b;
    if (idx_q == IDX_W'(IX_FLAG)) bus_rdata = {irqf, pf, af, uf, 4'h0};
    if (idx_q == IDX_W'(IX_PWR))  bus_rdata = 8'h80;
  end

  assign irq = irqf;

endmodule

// File: rtl/rtc_core_chk.sv
`timescale 1ns/1ps
module rtc_core_chk #(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          hold,
  input logic          halt,
  input logic          uip,
  input logic          pf,
  input logic          af,
  input logic          uf,
  input logic          irq,
  input logic          clr,
  input logic          sec_ev,
  input logic          per_ev,
  input logic [3:0]    rate
);

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0)); // R2

  AST_PERIODIC_NEEDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf) |-> ($past(rate) != 4'd0)); // R3

  AST_UIP_BEFORE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf) |-> $past(uip)); // R4

  AST_NO_UIP_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !uip); // R7

  AST_ALARM_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> uf); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pf || af || uf)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !sec_ev && !per_ev) |=> (!pf && !af && !uf)); // R11

endmodule

bind rtc_core rtc_core_chk #(.CW(SEC_LOG2)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cnt    (div_cnt),
  .hold   (div_hold),
  .halt   (ctl_b.halt),
  .uip    (uip),
  .pf     (pf),
  .af     (af),
  .uf     (uf),
  .irq    (irq),
  .clr    (clr_flags),
  .sec_ev (sec_ev),
  .per_ev (per_ev),
  .rate   (ctl_a[3:0])
);

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_base = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  always #2.5 clk = ~clk;

  rtc_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_base (tick_base),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_a, m_b, m_cnt, m_idx;
  int m_t[3];
  int m_al[3];
  bit m_pf, m_af, m_uf;

  function automatic int f_step(int v, bit bin);
    if (bin) return (v + 1) & 255;
    if ((v & 15) == 9) return (((v >> 4) + 1) << 4) & 255;
    return (v + 1) & 255;
  endfunction

  function automatic int f_top(int f, bit bin);
    if (f == 2) return bin ? 23 : 8'h23;
    return bin ? 59 : 8'h59;
  endfunction

  function automatic bit f_uip();
    return (((m_a >> 4) & 7) == 2) && !m_b[7] && (m_cnt >= 32760);
  endfunction

  function automatic bit f_irqf();
    return (m_pf && m_b[6]) || (m_af && m_b[5]) || (m_uf && m_b[4]);
  endfunction

  function automatic int f_exp(int i);
    case (i)
      0, 2, 4: return m_t[i / 2];
      1, 3, 5: return m_al[i / 2];
      10: return (int'(f_uip()) << 7) | m_a;
      11: return m_b;
      12: return (int'(f_irqf()) << 7) | (int'(m_pf) << 6) | (int'(m_af) << 5) | (int'(m_uf) << 4);
      13: return 8'h80;
      default: return 0;
    endcase
  endfunction

  function automatic string f_tag(int i);
    case (i)
      0, 2, 4: return "R5";
      1, 3, 5: return "R9";
      10: return "R4";
      11: return "R7";
      12: return "R10";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    int dv, rate, k, mask, ncnt;
    bit halt, bin, per, sec, hit, clr, carry, top;
    int nt[3];
    cyc++;
    if (!rst_n) begin
      m_a = 8'h20; m_b = 0; m_cnt = 0; m_idx = 0;
      for (int f = 0; f < 3; f++) begin m_t[f] = 0; m_al[f] = 0; end
      m_pf = 0; m_af = 0; m_uf = 0;
    end else begin
      dv = (m_a >> 4) & 7;
      rate = m_a & 15;
      halt = m_b[7];
      bin = m_b[2];
      per = 0; sec = 0;
      ncnt = m_cnt;
      if (dv >= 6) ncnt = 0;
      else if (tick_base && dv == 2) begin
        k = (rate == 1) ? 7 : (rate == 2) ? 8 : rate - 1;
        mask = (1 << k) - 1;
        per = (rate != 0) && ((m_cnt & mask) == mask);
        sec = !halt && (m_cnt == 32767);
        ncnt = (m_cnt + 1) & 32767;
      end
      carry = sec;
      for (int f = 0; f < 3; f++) begin
        nt[f] = m_t[f];
        if (carry) begin
          top = (m_t[f] == f_top(f, bin));
          nt[f] = top ? 0 : f_step(m_t[f], bin);
          carry = top;
        end
      end
      hit = sec;
      for (int f = 0; f < 3; f++)
        if (!(((m_al[f] >> 6) == 3) || (m_al[f] == nt[f]))) hit = 0;
      clr = bus_rd && bus_sel && (m_idx == 12);
      m_pf = (m_pf && !clr) || per;
      m_af = (m_af && !clr) || hit;
      m_uf = (m_uf && !clr) || sec;
      for (int f = 0; f < 3; f++) m_t[f] = nt[f];
      if (bus_wr && !bus_sel) m_idx = bus_wdata & 127;
      else if (bus_wr && bus_sel) begin
        case (m_idx)
          0, 2, 4: m_t[m_idx / 2] = bus_wdata;
          1, 3, 5: m_al[m_idx / 2] = bus_wdata;
          10: m_a = bus_wdata & 127;
          11: m_b = bus_wdata;
          default: ;
        endcase
      end
      m_cnt = ncnt;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (bus_rdata !== 8'(f_exp(m_idx))) begin
        n_fail++;
        $display("FAIL %s cycle %0d index %02h: rdata got %02h expected %02h",
                 f_tag(m_idx), cyc, m_idx, bus_rdata, 8'(f_exp(m_idx)));
      end
      n_chk++;
      if (irq !== f_irqf()) begin
        n_fail++;
        $display("FAIL R10 cycle %0d: irq got %0b expected %0b", cyc, irq, f_irqf());
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic set_idx(int i);
    bus_wr = 1; bus_sel = 0; bus_wdata = 8'(i);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic wr(int i, int d);
    bus_wr = 1; bus_sel = 0; bus_wdata = 8'(i);
    @(negedge clk);
    bus_sel = 1; bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 0; bus_sel = 0;
  endtask

  task automatic rd_chk(int i, int mask, int exp, string tag);
    set_idx(i);
    chk(tag, bus_rdata & mask, exp);
  endtask

  task automatic clr_flags();
    set_idx(12);
    bus_rd = 1; bus_sel = 1;
    @(negedge clk);
    bus_rd = 0; bus_sel = 0;
  endtask

  task automatic wait_update();
    int w;
    set_idx(10);
    w = 0;
    while (!bus_rdata[7] && w < 40000) begin
      @(negedge clk);
      w++;
    end
    chk("R4 window opens", int'(bus_rdata[7]), 1);
    repeat (7) @(negedge clk);
    chk("R4 window holds", int'(bus_rdata[7]), 1);
    @(negedge clk);
    chk("R4 window closes", int'(bus_rdata[7]), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    tick_base = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk(10, 8'hFF, 8'h20, "R1 ctl A");
    rd_chk(11, 8'hFF, 8'h00, "R1 ctl B");
    rd_chk(12, 8'hFF, 8'h00, "R1 flags");
    rd_chk(0, 8'hFF, 8'h00, "R1 seconds");
    rd_chk(5, 8'hFF, 8'h00, "R1 hour alarm");
    chk("R1 irq", int'(irq), 0);

    // R2 frozen divider code: no periodic event
    wr(10, 8'h03);
    repeat (40) @(negedge clk);
    rd_chk(12, 8'h40, 8'h00, "R2 frozen");

    // R3 periodic rate 3, enabled into irq
    wr(11, 8'h40);
    wr(10, 8'h23);
    repeat (12) @(negedge clk);
    rd_chk(12, 8'hC0, 8'hC0, "R3 rate3");
    chk("R10 irq periodic", int'(irq), 1);
    wr(10, 8'h20);
    clr_flags();
    rd_chk(12, 8'hFF, 8'h00, "R11 cleared");
    chk("R11 irq low", int'(irq), 0);

    // R3 rate 1 with gapped ticks
    wr(10, 8'h21);
    for (int i = 0; i < 420; i++) begin
      tick_base = (i % 3) != 0;
      @(negedge clk);
    end
    tick_base = 1;
    rd_chk(12, 8'h40, 8'h40, "R3 rate1");
    wr(10, 8'h20);
    clr_flags();

    // R12 read-only and unmapped
    wr(12, 8'hFF);
    rd_chk(12, 8'hFF, 8'h00, "R12 flag write");
    wr(13, 8'h00);
    rd_chk(13, 8'hFF, 8'h80, "R12 power");
    rd_chk(8'h20, 8'hFF, 8'h00, "R12 unmapped");

    // hold divider, load BCD 23:59:58 with alarm 00:00:xx
    wr(10, 8'hE0);
    rd_chk(10, 8'hFF, 8'h60, "R4 bit7 read-only");
    wr(0, 8'h58); wr(2, 8'h59); wr(4, 8'h23);
    wr(1, 8'hC0); wr(3, 8'h00); wr(5, 8'h00);
    wr(11, 8'h30);
    clr_flags();
    wr(10, 8'h20);
    wait_update();
    rd_chk(0, 8'hFF, 8'h59, "R5 seconds step");
    rd_chk(12, 8'hFF, 8'h90, "R8 update flag");
    clr_flags();
    wait_update();
    rd_chk(12, 8'hFF, 8'hB0, "R9 alarm on wrap");
    rd_chk(0, 8'hFF, 8'h00, "R5 seconds wrap");
    rd_chk(2, 8'hFF, 8'h00, "R5 minutes wrap");
    rd_chk(4, 8'hFF, 8'h00, "R5 hours wrap");
    clr_flags();

    // R6 binary mode, interrupts disabled
    wr(11, 8'h04);
    wr(0, 8'h3B); wr(2, 8'h3B); wr(4, 8'h17);
    wait_update();
    rd_chk(0, 8'hFF, 8'h00, "R6 binary seconds");
    rd_chk(4, 8'hFF, 8'h00, "R6 binary hours");
    rd_chk(12, 8'hFF, 8'h30, "R10 no enable no request");
    chk("R10 irq idle", int'(irq), 0);
    clr_flags();

    // R7 halt
    wr(11, 8'h84);
    wr(0, 8'h05);
    set_idx(10);
    repeat (33000) @(negedge clk);
    rd_chk(0, 8'hFF, 8'h05, "R7 halted seconds");
    rd_chk(12, 8'hFF, 8'h00, "R7 no update flag");

    summary();
  end

endmodule